// File: doc/BRIEF.md
# Two-Input Streaming Merge Unit

This block combines two streams of keyed records, each already in ascending key order, into a single ascending output stream. Each record carries a key, a payload that travels with it unchanged, and an end flag. A record with the end flag set is an in-band end-of-block marker.

While both inputs hold data records, the unit forwards the one with the lower key. When an input presents its end marker, the unit leaves that marker waiting at the input and passes the other input's records straight through. Once both inputs present end markers, the unit emits one merged end marker. Both input markers are consumed in the cycle in which that marker is accepted downstream. The unit then starts on the next block.

All three interfaces use valid/ready handshakes. The output is a single register holding at most one record, so a stalled output stalls both inputs.

Top module: `sort_stream_merge`

## Requirements
- R1: While reset is active and directly after it, with no input valid, out_valid_o, in0_ready_o and in1_ready_o are 0.
- R2: When both inputs present data records (end flag 0) and the output can accept a new record, the record with the lower key is consumed. One cycle later it appears on the output with its key and payload unchanged. At most one input is consumed per cycle, except in the end case of R6.
- R3: When both data keys are equal, input 0 is consumed first.
- R4: When one input is not valid and the other holds a data record, nothing is consumed and no record is output.
- R5: While one input presents an end marker and the other presents data records, the end marker is not consumed. The data records pass to the output in arrival order.
- R6: When both inputs present end markers, exactly one record with out_end_o=1, key 0 and payload 0 is output. Both end markers are consumed together, in the cycle in which that record is accepted, and not earlier.
- R7: While out_valid_o=1 and out_ready_i=0, the output record stays stable and neither input is consumed.
- R8: After a merged end marker is accepted, the next block on the inputs is merged by the same rules.
- R9: With out_ready_i held at 1 and both inputs supplying data, one record is forwarded per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in0_valid_i | input | 1 | Input 0 record valid |
| in0_ready_o | output | 1 | Input 0 record consumed when high with valid |
| in0_key_i | input | KEY_W | Input 0 key |
| in0_pay_i | input | PAY_W | Input 0 payload |
| in0_end_i | input | 1 | Input 0 end-of-block marker |
| in1_valid_i | input | 1 | Input 1 record valid |
| in1_ready_o | output | 1 | Input 1 record consumed when high with valid |
| in1_key_i | input | KEY_W | Input 1 key |
| in1_pay_i | input | PAY_W | Input 1 payload |
| in1_end_i | input | 1 | Input 1 end-of-block marker |
| out_valid_o | output | 1 | Output record valid |
| out_ready_i | input | 1 | Downstream accepts output record |
| out_key_o | output | KEY_W | Output key |
| out_pay_o | output | PAY_W | Output payload |
| out_end_o | output | 1 | Output is the merged end marker |

## Verification
The assertions assume that both sources keep the usual valid/ready rule: a presented record stays valid and unchanged until it is consumed. They also assume that each input's data keys ascend within a block, and that an end marker stays presented until the unit takes it. The bench keeps within these assumptions. Each source queue holds a valid record until the handshake that the design's ready shows at the clock edge, and it changes its drive only at the following falling edge. Every block is built from keys that never decrease, with occasional repeats to exercise ties. Random idle gaps on the sources and random output back-pressure vary the timing without breaking the handshake rule.

// File: rtl/sort_merge_pkg.sv
package sort_merge_pkg;
  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_0    = 2'd1,
    PICK_1    = 2'd2,
    PICK_END  = 2'd3
  } pick_e;
endpackage

// File: rtl/smerge_pick.sv
module smerge_pick
  import sort_merge_pkg::*;
#(
  parameter int KEY_W = 16
) (
  input  logic             v0_i,
  input  logic             e0_i,
  input  logic [KEY_W-1:0] k0_i,
  input  logic             v1_i,
  input  logic             e1_i,
  input  logic [KEY_W-1:0] k1_i,
  output pick_e            pick_o
);
  // Decision needs both heads; an ended input keeps its marker at the head.
  always_comb begin
    pick_o = PICK_NONE;
    if (v0_i && v1_i) begin
      unique case ({e0_i, e1_i})
        2'b11:   pick_o = PICK_END;
        2'b10:   pick_o = PICK_1;
        2'b01:   pick_o = PICK_0;
        default: pick_o = (k0_i <= k1_i) ? PICK_0 : PICK_1; // tie -> input 0
      endcase
    end
  end
endmodule

// File: rtl/smerge_oreg.sv
module smerge_oreg #(
  parameter int W = 33
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         clear_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      q_o     <= d_i;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sort_stream_merge.sv
module sort_stream_merge
  import sort_merge_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter int PAY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in0_valid_i,
  output logic             in0_ready_o,
  input  logic [KEY_W-1:0] in0_key_i,
  input  logic [PAY_W-1:0] in0_pay_i,
  input  logic             in0_end_i,
  input  logic             in1_valid_i,
  output logic             in1_ready_o,
  input  logic [KEY_W-1:0] in1_key_i,
  input  logic [PAY_W-1:0] in1_pay_i,
  input  logic             in1_end_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [KEY_W-1:0] out_key_o,
  output logic [PAY_W-1:0] out_pay_o,
  output logic             out_end_o
);
  localparam int REC_W = KEY_W + PAY_W + 1;

  pick_e            pick;
  logic             end_pend;
  logic             can_load;
  logic             load;
  logic [REC_W-1:0] rec_d;
  logic [REC_W-1:0] rec_q;

  smerge_pick #(.KEY_W(KEY_W)) u_pick (
    .v0_i  (in0_valid_i),
    .e0_i  (in0_end_i),
    .k0_i  (in0_key_i),
    .v1_i  (in1_valid_i),
    .e1_i  (in1_end_i),
    .k1_i  (in1_key_i),
    .pick_o(pick)
  );

  // Merged marker sits in the output; input markers stay until it is taken.
  assign end_pend = out_valid_o && out_end_o;
  assign can_load = (!out_valid_o || out_ready_i) && !end_pend;
  assign load     = can_load && (pick != PICK_NONE);

  always_comb begin
    unique case (pick)
      PICK_0:   rec_d = {1'b0, in0_key_i, in0_pay_i};
      PICK_1:   rec_d = {1'b0, in1_key_i, in1_pay_i};
      PICK_END: rec_d = {1'b1, {KEY_W{1'b0}}, {PAY_W{1'b0}}};
      default:  rec_d = '0;
    endcase
  end

  assign in0_ready_o = (can_load && pick == PICK_0) || (end_pend && out_ready_i);
  assign in1_ready_o = (can_load && pick == PICK_1) || (end_pend && out_ready_i);

  smerge_oreg #(.W(REC_W)) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .clear_i(out_valid_o && out_ready_i),
    .d_i    (rec_d),
    .valid_o(out_valid_o),
    .q_o    (rec_q)
  );

  assign out_end_o = rec_q[REC_W-1];
  assign out_key_o = rec_q[PAY_W +: KEY_W];
  assign out_pay_o = rec_q[PAY_W-1:0];

  p_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in0_ready_o && !in1_ready_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_key_o)
                                   && $stable(out_pay_o) && $stable(out_end_o));

  p_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in0_valid_i && in0_ready_o && !in0_end_i && in1_valid_i && !in1_end_i
      |-> in0_key_i <= in1_key_i);

  p_tie_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in1_valid_i && in1_ready_o && !in1_end_i && in0_valid_i && !in0_end_i
      |-> in1_key_i < in0_key_i);

  p_wait0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in1_valid_i |-> !in0_ready_o);

  p_wait1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in0_valid_i |-> !in1_ready_o);

  p_end_pop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in0_valid_i && in0_end_i && in0_ready_o
      |-> out_valid_o && out_end_o && out_ready_i && in1_ready_o && in1_end_i);

  p_two_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in0_ready_o && in1_ready_o |-> end_pend && in0_end_i && in1_end_i);

  p_end_fmt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_end_o |-> out_key_o == '0 && out_pay_o == '0);
endmodule

// File: tb/sort_stream_merge_bench.sv
module sort_stream_merge_bench;
  localparam int KW = 16;
  localparam int PW = 16;

  typedef struct {
    logic [KW-1:0] key;
    logic [PW-1:0] pay;
    logic          e;
  } rec_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in0_valid = 1'b0, in1_valid = 1'b0;
  logic in0_ready, in1_ready;
  logic [KW-1:0] in0_key = '0, in1_key = '0;
  logic [PW-1:0] in0_pay = '0, in1_pay = '0;
  logic in0_end = 1'b0, in1_end = 1'b0;
  logic out_valid, out_end;
  logic out_ready = 1'b0;
  logic [KW-1:0] out_key;
  logic [PW-1:0] out_pay;

  always #4 clk = ~clk;

  sort_stream_merge u_sort_stream_merge (
    .clk_i(clk), .rst_ni(rst_n),
    .in0_valid_i(in0_valid), .in0_ready_o(in0_ready), .in0_key_i(in0_key),
    .in0_pay_i(in0_pay), .in0_end_i(in0_end),
    .in1_valid_i(in1_valid), .in1_ready_o(in1_ready), .in1_key_i(in1_key),
    .in1_pay_i(in1_pay), .in1_end_i(in1_end),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_key_o(out_key),
    .out_pay_o(out_pay), .out_end_o(out_end)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  rec_t q0[$], q1[$], got[$], exp_l[$];
  int   exp_blk[$];
  int   nblk = 0;
  bit   en0 = 1, en1 = 1, rnd = 0;
  bit   ordy_force = 1;
  bit   pop0 = 0, pop1 = 0;
  logic [15:0] lfsr = 16'hACE1;
  // reference model state
  bit   mv = 0;
  rec_t mrec;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic add_block(input int ka[$], input int kb[$]);
    int i = 0, j = 0;
    rec_t r;
    rec_t a[$], b[$];
    foreach (ka[n]) begin
      r.key = KW'(ka[n]); r.pay = {4'(nblk), 1'b0, 11'(n)}; r.e = 0;
      a.push_back(r); q0.push_back(r);
    end
    foreach (kb[n]) begin
      r.key = KW'(kb[n]); r.pay = {4'(nblk), 1'b1, 11'(n)}; r.e = 0;
      b.push_back(r); q1.push_back(r);
    end
    r.key = '0; r.pay = '0; r.e = 1;
    q0.push_back(r); q1.push_back(r);
    while (i < a.size() || j < b.size()) begin
      if (j >= b.size() || (i < a.size() && a[i].key <= b[j].key)) begin
        exp_l.push_back(a[i]); i++;
      end else begin
        exp_l.push_back(b[j]); j++;
      end
      exp_blk.push_back(nblk);
    end
    exp_l.push_back(r);
    exp_blk.push_back(nblk);
    nblk++;
  endtask

  task automatic step();
    bit pend, ld, mr0, mr1;
    rec_t c0, c1, nrec;
    string lbl;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (pop0) begin void'(q0.pop_front()); in0_valid = 0; pop0 = 0; end
    if (pop1) begin void'(q1.pop_front()); in1_valid = 0; pop1 = 0; end
    if (!in0_valid && q0.size() > 0 && en0 && (!rnd || lfsr[0])) begin
      in0_valid = 1; in0_key = q0[0].key; in0_pay = q0[0].pay; in0_end = q0[0].e;
    end
    if (!in1_valid && q1.size() > 0 && en1 && (!rnd || lfsr[3])) begin
      in1_valid = 1; in1_key = q1[0].key; in1_pay = q1[0].pay; in1_end = q1[0].e;
    end
    out_ready = rnd ? (lfsr[5] | lfsr[7]) : ordy_force;
    #1;
    c0.key = in0_key; c0.pay = in0_pay; c0.e = in0_end;
    c1.key = in1_key; c1.pay = in1_pay; c1.e = in1_end;
    pend = mv && mrec.e;
    ld = 0; mr0 = 0; mr1 = 0;
    nrec.key = '0; nrec.pay = '0; nrec.e = 1;
    if (pend) begin
      mr0 = out_ready; mr1 = out_ready;
    end else if ((!mv || out_ready) && in0_valid && in1_valid) begin
      ld = 1;
      if (c0.e && c1.e) ;
      else if (c0.e) begin nrec = c1; mr1 = 1; end
      else if (c1.e || c0.key <= c1.key) begin nrec = c0; mr0 = 1; end
      else begin nrec = c1; mr1 = 1; end
    end
    if (pend || (in0_valid && in0_end) || (in1_valid && in1_end)) lbl = "R6";
    else if (mv && !out_ready) lbl = "R7";
    else if (!(in0_valid && in1_valid)) lbl = "R4";
    else if (in0_key == in1_key) lbl = "R3";
    else lbl = "R2";
    if ((in0_valid && in1_valid) && (in0_end != in1_end)) lbl = "R5";
    chk(in0_ready == mr0, lbl, "in0_ready", in0_ready, mr0);
    chk(in1_ready == mr1, lbl, "in1_ready", in1_ready, mr1);
    chk(out_valid == mv, "R9", "out_valid", out_valid, mv);
    if (mv && out_valid) begin
      chk(out_end == mrec.e, "R6", "out_end", out_end, mrec.e);
      chk(out_key == mrec.key, "R2", "out_key", out_key, mrec.key);
      chk(out_pay == mrec.pay, "R2", "out_pay", out_pay, mrec.pay);
    end
    if (out_valid && out_ready) begin
      rec_t g;
      g.key = out_key; g.pay = out_pay; g.e = out_end;
      got.push_back(g);
    end
    pop0 = in0_valid && in0_ready;
    pop1 = in1_valid && in1_ready;
    if (ld) begin mv = 1; mrec = nrec; end
    else if (mv && out_ready) mv = 0;
  endtask

  initial begin
    int ka[$], kb[$];
    int k;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 0 && in0_ready == 0 && in1_ready == 0, "R1", "reset outputs",
        {out_valid, in0_ready, in1_ready}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(out_valid == 0 && in0_ready == 0 && in1_ready == 0, "R1", "post-reset idle",
        {out_valid, in0_ready, in1_ready}, 0);

    add_block('{1, 3, 3, 7, 9}, '{2, 3, 8, 20});
    en1 = 0;
    repeat (6) begin
      step();
      chk(!out_valid && !in0_ready, "R4", "one-sided wait", {out_valid, in0_ready}, 0);
    end
    en1 = 1;
    repeat (3) step();
    ordy_force = 0;
    step();
    begin
      logic [KW-1:0] hk;
      hk = out_key;
      repeat (4) begin
        step();
        chk(out_valid && out_key == hk, "R7", "stalled output held", out_key, hk);
        chk(!in0_ready && !in1_ready, "R7", "inputs stalled", {in0_ready, in1_ready}, 0);
      end
    end
    ordy_force = 1;

    add_block('{}, '{5, 6});
    add_block('{4, 10, 12}, '{});
    add_block('{}, '{});
    begin
      int fw = 0;
      while (q0.size() > 0 || q1.size() > 0 || mv || in0_valid || in1_valid) begin
        step();
        if (out_valid && out_ready && !out_end) fw++;
      end
      chk(fw > 0, "R9", "records forwarded", fw, 1);
    end

    // R9: back-to-back throughput with both inputs full
    add_block('{10, 11, 12, 13}, '{14, 15, 16, 17});
    begin
      int run = 0;
      repeat (8) begin
        step();
        if (out_valid && !out_end) run++;
      end
      chk(run >= 6, "R9", "one record per cycle", run, 6);
    end

    rnd = 1;
    repeat (6) begin
      ka.delete(); kb.delete();
      k = lfsr[3:0];
      repeat (6 + lfsr[2:0]) begin k += lfsr[1:0]; ka.push_back(k); step(); end
      k = lfsr[5:2];
      repeat (5 + lfsr[3:1]) begin k += lfsr[2:1]; kb.push_back(k); step(); end
      add_block(ka, kb);
    end
    while (q0.size() > 0 || q1.size() > 0 || mv || in0_valid || in1_valid) step();

    chk(got.size() == exp_l.size(), "R6", "output count", got.size(), exp_l.size());
    begin
      int ends = 0;
      foreach (got[i]) if (got[i].e) ends++;
      chk(ends == nblk, "R6", "one end marker per block", ends, nblk);
    end
    foreach (exp_l[i]) begin
      if (i < got.size()) begin
        string r;
        if (exp_l[i].e) r = "R6";
        else if (exp_blk[i] > 0) r = "R8";
        else if (i > 0 && exp_l[i-1].key == exp_l[i].key && !exp_l[i-1].e) r = "R3";
        else r = "R2";
        chk(got[i].e == exp_l[i].e && got[i].key == exp_l[i].key && got[i].pay == exp_l[i].pay,
            r, "merged stream", {got[i].key, got[i].pay}, {exp_l[i].key, exp_l[i].pay});
      end
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule